// File: doc/BRIEF.md
# Synthesizer Divider Configuration Front End

This block holds the divider settings of a PLL clock synthesizer and decides where they come from. It keeps a 9-bit feedback divider value M, a 2-bit post-divider code N and a 3-bit test-select code T. The PLL drives its VCO to 8×M times a reference equal to the crystal frequency divided by 16. For that reason M reaches the feedback divider exactly as it was programmed. The block also decodes N into a one-hot post-divide ratio for the output divider.

Two sources write the settings. A parallel bus carries M and N and has a load strobe. While the strobe is low, the latched settings follow the bus. The rising edge of the strobe freezes the bus value into the latches. A three-wire serial port with clock, data and load fills a 14-bit shift register, and a falling edge on the serial load commits that register to all three settings. The parallel path has priority over the serial path. All inputs are asynchronous to the system clock and are brought into that domain through two-flop synchronisers. A single-cycle pulse marks every change to the latched settings.

Top module: `synth_cfg_frontend`

## Requirements
- R1: While reset is asserted, M reads 9'h1FF, N reads 2'b11, T reads 3'b000, the ratio output reads 4'b1000 and cfgValid is low. These values match a parallel bus held at all ones by pull-ups.
- R2: Each rising edge of the serial clock shifts the serial data bit into bit 0 of a 14-bit shift register, and the older bits move toward bit 13. A frame is T[2:0], then N[1:0], then M[8:0], each field sent most significant bit first. Only the last 14 bits shifted are kept.
- R3: When the parallel load is high, a falling edge on the serial load copies shift register bits [13:11] to T, bits [10:9] to N and bits [8:0] to M.
- R4: A rising edge on the parallel load captures the bus into M and N and leaves T unchanged. While the parallel load stays high, later changes on the bus have no effect.
- R5: While the parallel load is low, M and N follow the bus. A serial load falling edge in this state changes none of M, N or T.
- R6: The ratio output is one-hot and follows N. Code 00 gives 4'b0001 (divide by 1), 01 gives 4'b0010 (divide by 2), 10 gives 4'b0100 (divide by 4) and 11 gives 4'b1000 (divide by 8).
- R7: cfgValid is high for exactly one cycle in the same cycle as each update of the latched values. An update is a serial commit, a parallel capture, or a change in value while the bus is being followed. In any other cycle cfgValid is low.
- R8: Each input passes through two synchroniser flops. A load edge that is stable before clock edge k updates the outputs at edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sClkIn | input | 1 | Serial port clock (asynchronous) |
| sDataIn | input | 1 | Serial port data (asynchronous) |
| sLoadIn | input | 1 | Serial commit strobe, acts on its falling edge |
| pLoadIn | input | 1 | Parallel load: low follows the bus, rising edge captures it |
| mPinsIn | input | 9 | Parallel feedback divider value |
| nPinsIn | input | 2 | Parallel post-divider code |
| mOut | output | 9 | Latched feedback divider value |
| nOut | output | 2 | Latched post-divider code |
| tOut | output | 3 | Latched test-select code |
| ratioOut | output | 4 | One-hot post-divide ratio |
| cfgValid | output | 1 | One-cycle pulse on every settings update |

## Verification
The bench runs serial frames with different field contents. This shows whether bit order and field placement are right, since a swapped field or a reversed bit changes a known result. An over-long 16-bit frame shows that only the last 14 bits are kept. The parallel bus is driven once with the strobe low and once with the strobe high, and a serial commit is sent while the strobe is low. These patterns separate following the bus, capturing it, and giving the parallel path priority. One commit is sampled cycle by cycle to pin down the two-flop latency. Every N code is decoded against its ratio.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  // Strobes handed from the control module to the datapath, one cycle wide
  typedef struct packed {
    logic shiftEn;     // serial clock rose: shift one bit
    logic serCommit;   // serial load fell while parallel path idle
    logic parCapture;  // parallel load rose
    logic parTrack;    // parallel load low: follow the bus
  } cfg_strobe_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= INIT;
      syncOut <= INIT;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sClkIn,
  input  logic        sLoadIn,
  input  logic        pLoadIn,
  output cfg_strobe_t strobe
);

  localparam int NUM_CTRL = 3;

  logic [NUM_CTRL-1:0] ctrlSync;
  logic [NUM_CTRL-1:0] ctrlPrev;
  logic sClkS, sLoadS, pLoadS;
  logic sClkP, sLoadP, pLoadP;

  cfg_sync #(.W(NUM_CTRL), .INIT('0)) ctrlSync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({pLoadIn, sLoadIn, sClkIn}),
    .syncOut(ctrlSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlPrev <= '0;
    else       ctrlPrev <= ctrlSync;
  end

  assign {pLoadS, sLoadS, sClkS} = ctrlSync;
  assign {pLoadP, sLoadP, sClkP} = ctrlPrev;

  always_comb begin
    strobe            = '0;
    strobe.shiftEn    = sClkS & ~sClkP;
    strobe.parTrack   = ~pLoadS;
    strobe.parCapture = pLoadS & ~pLoadP;
    // parallel path wins: commit only when parallel is neither tracking nor capturing
    strobe.serCommit  = ~sLoadS & sLoadP & pLoadS & pLoadP;
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.serCommit |-> !(strobe.parTrack || strobe.parCapture)); // R5

  AST_CAPTURE_AFTER_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.parCapture |-> $past(strobe.parTrack)); // R4

endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import synth_cfg_pkg::*;
#(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int TW = 3,
  localparam int SW = TW + NW + MW,
  localparam int RW = 1 << NW,
  localparam int DW = 1 + NW + MW
) (
  input  logic          clk,
  input  logic          rstN,
  input  cfg_strobe_t   strobe,
  input  logic          sDataIn,
  input  logic [MW-1:0] mPinsIn,
  input  logic [NW-1:0] nPinsIn,
  output logic [MW-1:0] mLat,
  output logic [NW-1:0] nLat,
  output logic [TW-1:0] tLat,
  output logic [RW-1:0] ratio,
  output logic          cfgValid
);

  localparam logic [DW-1:0] DATA_INIT = {1'b0, {NW{1'b1}}, {MW{1'b1}}};

  logic [DW-1:0] dataSync;
  logic          sDataS;
  logic [MW-1:0] mSync;
  logic [NW-1:0] nSync;
  logic [SW-1:0] shiftReg;
  logic          trackChange;

  cfg_sync #(.W(DW), .INIT(DATA_INIT)) dataSync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({sDataIn, nPinsIn, mPinsIn}),
    .syncOut(dataSync)
  );

  assign {sDataS, nSync, mSync} = dataSync;

  // serial shift register, newest bit at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[SW-2:0], sDataS};
  end

  assign trackChange = ({nSync, mSync} != {nLat, mLat});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLat     <= '1;
      nLat     <= '1;
      tLat     <= '0;
      cfgValid <= 1'b0;
    end else if (strobe.parTrack) begin
      mLat     <= mSync;
      nLat     <= nSync;
      cfgValid <= trackChange;
    end else if (strobe.parCapture) begin
      mLat     <= mSync;
      nLat     <= nSync;
      cfgValid <= 1'b1;
    end else if (strobe.serCommit) begin
      tLat     <= shiftReg[SW-1 -: TW];
      nLat     <= shiftReg[MW +: NW];
      mLat     <= shiftReg[MW-1:0];
      cfgValid <= 1'b1;
    end else begin
      cfgValid <= 1'b0;
    end
  end

  // post-divide ratio decode, one bit per code
  for (genvar i = 0; i < RW; i++) begin : g_ratio
    assign ratio[i] = (nLat == NW'(i));
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> shiftReg[0] == $past(sDataS)); // R2

  AST_SERIAL_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.serCommit |=> {tLat, nLat, mLat} == $past(shiftReg)); // R3

  AST_PAR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.parCapture |=> (mLat == $past(mSync)) && (nLat == $past(nSync))
                          && $stable(tLat)); // R4

  AST_TRACK_KEEPS_T: assert property (@(posedge clk) disable iff (!rstN)
    strobe.parTrack |=> $stable(tLat)); // R5

  AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({mLat, nLat, tLat}) |-> cfgValid); // R7

  AST_RATIO_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ratio) && (ratio != '0)); // R6

endmodule

// File: rtl/synth_cfg_frontend.sv
module synth_cfg_frontend
  import synth_cfg_pkg::*;
#(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int TW = 3,
  localparam int RW = 1 << NW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sClkIn,
  input  logic          sDataIn,
  input  logic          sLoadIn,
  input  logic          pLoadIn,
  input  logic [MW-1:0] mPinsIn,
  input  logic [NW-1:0] nPinsIn,
  output logic [MW-1:0] mOut,
  output logic [NW-1:0] nOut,
  output logic [TW-1:0] tOut,
  output logic [RW-1:0] ratioOut,
  output logic          cfgValid
);

  cfg_strobe_t strobe;

  cfg_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sClkIn (sClkIn),
    .sLoadIn(sLoadIn),
    .pLoadIn(pLoadIn),
    .strobe (strobe)
  );

  cfg_datapath #(.MW(MW), .NW(NW), .TW(TW)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sDataIn (sDataIn),
    .mPinsIn (mPinsIn),
    .nPinsIn (nPinsIn),
    .mLat    (mOut),
    .nLat    (nOut),
    .tLat    (tOut),
    .ratio   (ratioOut),
    .cfgValid(cfgValid)
  );

endmodule

// File: tb/synth_cfg_frontend_tb_top.sv
`timescale 1ns/1ps
module synth_cfg_frontend_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sClkIn = 1'b0, sDataIn = 1'b0, sLoadIn = 1'b0, pLoadIn = 1'b0;
  logic [8:0] mPinsIn = 9'h055;
  logic [1:0] nPinsIn = 2'b01;
  logic [8:0] mOut;
  logic [1:0] nOut;
  logic [2:0] tOut;
  logic [3:0] ratioOut;
  logic       cfgValid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  synth_cfg_frontend dut_i (
    .clk(clk), .rstN(rstN), .sClkIn(sClkIn), .sDataIn(sDataIn),
    .sLoadIn(sLoadIn), .pLoadIn(pLoadIn), .mPinsIn(mPinsIn), .nPinsIn(nPinsIn),
    .mOut(mOut), .nOut(nOut), .tOut(tOut), .ratioOut(ratioOut), .cfgValid(cfgValid)
  );

  // ---------------- behavioural reference model ----------------
  // input vector: m[8:0], n[10:9], sdata[11], sclk[12], sload[13], pload[14]
  localparam logic [14:0] IN_RST = 15'h07FF;
  logic [14:0] in1, in2, inPrev;
  logic [13:0] refShift;
  logic [8:0]  refM;
  logic [1:0]  refN;
  logic [2:0]  refT;
  logic        refV;
  int          refPulses = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      in1 <= IN_RST; in2 <= IN_RST; inPrev <= IN_RST;
      refShift <= '0; refM <= 9'h1FF; refN <= 2'b11; refT <= 3'b000; refV <= 1'b0;
    end else begin
      inPrev <= in2;
      in2    <= in1;
      in1    <= {pLoadIn, sLoadIn, sClkIn, sDataIn, nPinsIn, mPinsIn};
      if (in2[12] && !inPrev[12]) refShift <= {refShift[12:0], in2[11]};
      if (!in2[14]) begin
        refM <= in2[8:0]; refN <= in2[10:9];
        refV <= (in2[10:0] != {refN, refM});
      end else if (!inPrev[14]) begin
        refM <= in2[8:0]; refN <= in2[10:9]; refV <= 1'b1;
      end else if (!in2[13] && inPrev[13]) begin
        {refT, refN, refM} <= refShift; refV <= 1'b1;
      end else begin
        refV <= 1'b0;
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("R3/R4/R5 M vs model", mOut, refM);
      check("R3/R4/R5 N vs model", nOut, refN);
      check("R3 T vs model", tOut, refT);
      check("R7 cfgValid vs model", cfgValid, refV);
      check("R6 ratio vs model", ratioOut, 1 << refN);
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // shift out the lowest 'count' bits of 'bits', MSB first, then raise load
  task automatic serialShift(input logic [15:0] bits, input int count);
    for (int i = count - 1; i >= 0; i--) begin
      @(negedge clk); sDataIn = bits[i]; sClkIn = 1'b0;
      waitCyc(3);
      sClkIn = 1'b1;
      waitCyc(3);
    end
    sClkIn = 1'b0;
    sLoadIn = 1'b1;
    waitCyc(4);
  endtask

  task automatic commitFall();
    @(negedge clk); sLoadIn = 1'b0;
    waitCyc(5);
  endtask

  // watchdog
  initial begin
    waitCyc(100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    waitCyc(3);
    // R1: reset values
    check("R1 M reset", mOut, 9'h1FF);
    check("R1 N reset", nOut, 2'b11);
    check("R1 T reset", tOut, 3'b000);
    check("R1 ratio reset", ratioOut, 4'b1000);
    check("R1 valid reset", cfgValid, 0);
    rstN = 1'b1;
    waitCyc(6);
    // R5: parallel load low follows the bus
    check("R5 M tracks bus", mOut, 9'h055);
    check("R5 N tracks bus", nOut, 2'b01);
    check("R6 ratio div2", ratioOut, 4'b0010);
    mPinsIn = 9'h0F0; nPinsIn = 2'b10;
    waitCyc(5);
    check("R5 M tracks new bus", mOut, 9'h0F0);
    // R5: serial commit ignored while parallel load low
    serialShift({2'b00, 3'd7, 2'b00, 9'h123}, 14);
    commitFall();
    check("R5 M after ignored commit", mOut, 9'h0F0);
    check("R5 T after ignored commit", tOut, 3'd0);
    // R4: capture on rising parallel load
    @(negedge clk); pLoadIn = 1'b1;
    waitCyc(5);
    mPinsIn = 9'h00A; nPinsIn = 2'b00;
    waitCyc(6);
    check("R4 M ignores bus while high", mOut, 9'h0F0);
    check("R4 N ignores bus while high", nOut, 2'b10);
    // R2/R3/R8: serial frame T=5 N=2 M=1A3 with latency probe
    serialShift({2'b00, 3'd5, 2'b10, 9'h1A3}, 14);
    @(negedge clk); sLoadIn = 1'b0;
    @(negedge clk);
    check("R8 no update after 1 edge", mOut, 9'h0F0);
    @(negedge clk);
    check("R8 no update after 2 edges", mOut, 9'h0F0);
    check("R8 valid low after 2 edges", cfgValid, 0);
    @(negedge clk);
    check("R8 M updated at 3rd edge", mOut, 9'h1A3);
    check("R7 valid pulse", cfgValid, 1);
    @(negedge clk);
    check("R7 valid one cycle", cfgValid, 0);
    check("R3 T", tOut, 3'd5);
    check("R3 N", nOut, 2'b10);
    check("R6 ratio div4", ratioOut, 4'b0100);
    waitCyc(3);
    // R2: 16-bit frame, first two bits dropped
    serialShift({2'b11, 3'd2, 2'b11, 9'h1FE}, 16);
    commitFall();
    check("R2 T long frame", tOut, 3'd2);
    check("R2 N long frame", nOut, 2'b11);
    check("R2 M long frame", mOut, 9'h1FE);
    check("R6 ratio div8", ratioOut, 4'b1000);
    // R4: low then high parallel load captures bus, T kept
    @(negedge clk); pLoadIn = 1'b0;
    waitCyc(4);
    @(negedge clk); pLoadIn = 1'b1;
    waitCyc(5);
    check("R4 M captured", mOut, 9'h00A);
    check("R4 N captured", nOut, 2'b00);
    check("R4 T kept", tOut, 3'd2);
    check("R6 ratio div1", ratioOut, 4'b0001);
    // R3: M value zero passes unchanged
    serialShift({2'b00, 3'd1, 2'b01, 9'h000}, 14);
    commitFall();
    check("R3 M zero", mOut, 9'h000);
    check("R3 T one", tOut, 3'd1);
    waitCyc(4);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule